// File: doc/BRIEF.md
# Multilevel Sine PWM Gate Generator

This block drives the switches of one inverter phase leg with sine-triangle pulse width modulation. A phase accumulator walks a 256-step sine table, the sample is scaled by a modulation index, and the scaled reference is compared with one, two or four triangular carriers. The carriers are stacked in the same phase, one above the other, across the reference range. The number of comparators that are high is the output level code, and that code selects which switches of the leg conduct.

The leg type is chosen at run time. A two-level leg uses two switches, a three-level clamped leg uses four and a five-level clamped leg uses eight. Each upper switch has a paired lower switch that is always its complement, so only adjacent levels are reached through the comparator chain. New settings for frequency, carrier period, modulation index and leg type are taken only at a carrier peak. A three-phase system uses three instances that share settings, with the phase accumulators offset by a third of a turn.

Top module: `msp_gate_gen`

## Requirements
- R1: While rst_n is low, gate and level are all zero. After release, the phase, the carrier counter and every held setting are zero and the held leg type is code 3. The output register therefore also shows all zeros after the first clock edge.
- R2: The carrier counter starts at 0, counts up by one each clock to the held half period P, then counts down by one to 0, and repeats. One carrier period is 2P clocks. P must be at least 2.
- R3: phase_step, carrier_half, mod_index and leg_mode are copied into held registers only at a peak. A peak is a clock where the counter is counting up and has reached P; the first clock after reset is one. Input changes between peaks have no effect on the outputs until the next peak.
- R4: Each clock the phase accumulator adds the held step. Its top 8 bits select a sine sample taken at the centre of that 1/256 turn. The sample is scaled by mod_index/256 to give m·sinθ. The reference is u = (N−1)·P·(1 + m·sinθ)/2, accurate to within 2% of (N−1)·P/2 plus 2 counts.
- R5: Carrier k (k = 0..N−2) is k·P + counter. Comparator k is high when u is greater than carrier k. The level output is the number of high comparators (0..N−1). Gate and level are registered and show the state from one clock earlier.
- R6: In three-level mode (leg_mode 1), level 2 gives gate 8'b0000_0011 (S1,S2), level 1 gives 8'b0000_0110 (S2,S3) and level 0 gives 8'b0000_1100 (S3,S4).
- R7: In five-level mode (leg_mode 2), gate[k−1] (switch Sk, k = 1..4) is on when level ≥ 5−k, and gate[3+k] is the complement of gate[k−1].
- R8: In two-level mode (leg_mode 0), gate[0] is on when level is 1 and gate[1] is its complement. gate[7:2] stay zero, and in three-level mode gate[7:4] stay zero.
- R9: Leg code 3 turns every gate off and holds level at 0.
- R10: In every active mode exactly one switch of each pair is on, so N−1 gate bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| phase_step | input | 32 | Phase increment per clock (reference frequency) |
| carrier_half | input | 16 | Carrier half period P in clocks, at least 2 |
| mod_index | input | 8 | Modulation index, unsigned, value/256 |
| leg_mode | input | 2 | 0 two-level, 1 three-level, 2 five-level, 3 off |
| gate | output | 8 | Switch gates, bit k−1 is Sk |
| level | output | 3 | Output level code (number of high comparators) |

## Verification
The embedded properties assume that rst_n is released in step with the clock and that carrier_half is never below 2 once loaded, so the counter turns at both ends. Leg codes outside 0 to 2 are treated as off, so any two-bit value is legal. The stimulus only uses half periods of 6 to 20 and changes inputs 2 ns after a rising edge, which keeps every setting change clear of the peak sample. Where the ideal reference sits within the stated tolerance of a carrier, the level comparison is skipped for that clock, but the pattern check against the observed level still applies.

// File: rtl/msp_pkg.sv
package msp_pkg;

  localparam int MAX_CMP = 4;
  localparam int GATE_W  = 2 * MAX_CMP;
  localparam int LVL_W   = $clog2(MAX_CMP + 1);

  typedef enum logic [1:0] {
    LEG_2L  = 2'd0,
    LEG_3L  = 2'd1,
    LEG_5L  = 2'd2,
    LEG_OFF = 2'd3
  } leg_mode_e;

  // number of carriers / comparators for a leg type
  function automatic logic [LVL_W-1:0] cmp_count(input leg_mode_e m);
    case (m)
      LEG_2L:  return LVL_W'(1);
      LEG_3L:  return LVL_W'(2);
      LEG_5L:  return LVL_W'(4);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/msp_carrier.sv
module msp_carrier #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] half_per,
  output logic [PER_W-1:0] cnt,
  output logic             rising,
  output logic             peak
);

  logic [PER_W-1:0] cnt_d;
  logic             rising_d;

  assign peak = rising && (cnt >= half_per);

  always_comb begin
    cnt_d    = cnt;
    rising_d = rising;
    if (rising) begin
      if (peak) begin
        rising_d = 1'b0;
        cnt_d    = (cnt == '0) ? cnt : cnt - 1'b1;
      end else begin
        cnt_d    = cnt + 1'b1;
      end
    end else if (cnt == '0) begin
      rising_d = 1'b1;
      cnt_d    = PER_W'(1);
    end else begin
      cnt_d    = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rising <= 1'b1;
    end else begin
      cnt    <= cnt_d;
      rising <= rising_d;
    end
  end

  AST_CAR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rising && !peak) |=> (cnt == $past(cnt) + PER_W'(1))); // R2
  AST_CAR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!rising && cnt != '0) |=> (cnt == $past(cnt) - PER_W'(1))); // R2

endmodule

// File: rtl/msp_reference.sv
module msp_reference #(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 8,
  parameter int SIN_W   = 8,
  parameter int MI_W    = 8,
  localparam int REF_W  = SIN_W + MI_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PHASE_W-1:0]      step,
  input  logic [MI_W-1:0]         mod_idx,
  output logic signed [REF_W-1:0] ref_val
);

  localparam int QAW  = LUT_AW - 2;
  localparam int QD   = 2 ** QAW;
  localparam int PI_H = 2 ** LUT_AW;          // half turn in half-steps
  localparam int AMP  = 2 ** (SIN_W - 1) - 1;

  // rational sine approximation evaluated at the centre of quarter step j
  function automatic int quarter_sine(input int j);
    int t, p, num, den;
    t   = 2 * j + 1;
    p   = t * (PI_H - t);
    num = 16 * p * AMP;
    den = 5 * PI_H * PI_H - 4 * p;
    return (num + den / 2) / den;
  endfunction

  logic signed [SIN_W-1:0] qtab [QD];

  for (genvar g = 0; g < QD; g++) begin : g_qtab
    assign qtab[g] = SIN_W'(quarter_sine(g));
  end

  logic [PHASE_W-1:0]      phase, phase_d;
  logic [LUT_AW-1:0]       idx;
  logic [1:0]              quad;
  logic [QAW-1:0]          qidx;
  logic signed [SIN_W-1:0] mag, sample;
  logic signed [REF_W-1:0] sample_x, mi_x;

  assign phase_d = phase + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_d;
  end

  always_comb begin
    idx      = phase[PHASE_W-1 -: LUT_AW];
    quad     = idx[LUT_AW-1 -: 2];
    qidx     = quad[0] ? ~idx[QAW-1:0] : idx[QAW-1:0];
    mag      = qtab[qidx];
    sample   = quad[1] ? -mag : mag;
    sample_x = REF_W'(sample);
    mi_x     = $signed({{(REF_W-MI_W){1'b0}}, mod_idx});
    ref_val  = sample_x * mi_x;
  end

endmodule

// File: rtl/msp_level_cmp.sv
module msp_level_cmp
  import msp_pkg::*;
#(
  parameter int PER_W = 16,
  parameter int REF_W = 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  leg_mode_e               mode,
  input  logic [PER_W-1:0]        half_per,
  input  logic [PER_W-1:0]        cnt,
  input  logic signed [REF_W-1:0] ref_val,
  output logic [GATE_W-1:0]       gate_q,
  output logic [LVL_W-1:0]        level_q
);

  localparam int SPW = PER_W + 2;     // span up to 4 * P
  localparam int SH  = REF_W - 1;     // scale shift
  localparam logic signed [REF_W-1:0] OFS = REF_W'(2 ** (SH - 1));

  logic [LVL_W-1:0]       n_cmp;
  logic [SPW-1:0]         span, u_ref;
  logic [REF_W-1:0]       ref_pos;
  logic [SPW+REF_W-1:0]   prod;
  logic [MAX_CMP-1:0]     cmp;
  logic [LVL_W-1:0]       hits;
  logic [GATE_W-1:0]      gate_d;

  always_comb begin
    n_cmp   = cmp_count(mode);
    span    = {2'b00, half_per} * SPW'(n_cmp);
    ref_pos = REF_W'(ref_val + OFS);
    prod    = SPW'(span) * (SPW+REF_W)'(ref_pos);
    u_ref   = SPW'(prod >> SH);
  end

  for (genvar k = 0; k < MAX_CMP; k++) begin : g_cmp
    logic [SPW-1:0] carrier_k;
    assign carrier_k = SPW'(k) * {2'b00, half_per} + {2'b00, cnt};
    assign cmp[k]    = (LVL_W'(k) < n_cmp) && (u_ref > carrier_k);
  end

  always_comb begin
    hits = '0;
    for (int k = 0; k < MAX_CMP; k++) hits = hits + LVL_W'(cmp[k]);
  end

  // upper switch i+1 on when enough comparators are high, lower one is its complement
  always_comb begin
    logic on;
    gate_d = '0;
    on     = 1'b0;
    for (int i = 0; i < MAX_CMP; i++) begin
      if (i < int'(n_cmp)) begin
        on                     = int'(hits) >= int'(n_cmp) - i;
        gate_d[i]              = on;
        gate_d[int'(n_cmp)+i]  = !on;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= '0;
      level_q <= '0;
    end else begin
      gate_q  <= gate_d;
      level_q <= hits;
    end
  end

  AST_PAIR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (n_cmp != '0) |=> ($countones(gate_q) == int'($past(n_cmp)))); // R10
  AST_OFF_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (n_cmp == '0) |=> (gate_q == '0 && level_q == '0)); // R9
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level_q <= $past(n_cmp))); // R5

endmodule

// File: rtl/msp_gate_gen.sv
module msp_gate_gen
  import msp_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 8,
  parameter int SIN_W   = 8,
  parameter int MI_W    = 8,
  parameter int PER_W   = 16,
  localparam int REF_W  = SIN_W + MI_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phase_step,
  input  logic [PER_W-1:0]   carrier_half,
  input  logic [MI_W-1:0]    mod_index,
  input  logic [1:0]         leg_mode,
  output logic [GATE_W-1:0]  gate,
  output logic [LVL_W-1:0]   level
);

  logic [PHASE_W-1:0]      step_q, step_d;
  logic [PER_W-1:0]        per_q, per_d;
  logic [MI_W-1:0]         mi_q, mi_d;
  leg_mode_e               mode_q, mode_d;
  logic                    peak, rising;
  logic [PER_W-1:0]        cnt;
  logic signed [REF_W-1:0] ref_val;

  // settings are taken only at a carrier peak
  always_comb begin
    step_d = step_q;
    per_d  = per_q;
    mi_d   = mi_q;
    mode_d = mode_q;
    if (peak) begin
      step_d = phase_step;
      per_d  = carrier_half;
      mi_d   = mod_index;
      mode_d = leg_mode_e'(leg_mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      per_q  <= '0;
      mi_q   <= '0;
      mode_q <= LEG_OFF;
    end else begin
      step_q <= step_d;
      per_q  <= per_d;
      mi_q   <= mi_d;
      mode_q <= mode_d;
    end
  end

  msp_carrier #(.PER_W(PER_W)) u_carrier (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_per (per_q),
    .cnt      (cnt),
    .rising   (rising),
    .peak     (peak)
  );

  msp_reference #(
    .PHASE_W (PHASE_W),
    .LUT_AW  (LUT_AW),
    .SIN_W   (SIN_W),
    .MI_W    (MI_W)
  ) u_reference (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step_q),
    .mod_idx (mi_q),
    .ref_val (ref_val)
  );

  msp_level_cmp #(
    .PER_W (PER_W),
    .REF_W (REF_W)
  ) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .half_per (per_q),
    .cnt      (cnt),
    .ref_val  (ref_val),
    .gate_q   (gate),
    .level_q  (level)
  );

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !peak |=> ($stable(step_q) && $stable(per_q) && $stable(mi_q) && $stable(mode_q))); // R3
  AST_PEAK_RISING: assert property (@(posedge clk) disable iff (!rst_n)
    peak |=> !rising); // R2

endmodule

// File: tb/sim_msp_gate_gen.sv
module sim_msp_gate_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] phase_step = '0;
  logic [15:0] carrier_half = '0;
  logic [7:0]  mod_index = '0;
  logic [1:0]  leg_mode = 2'd3;
  logic [7:0]  gate;
  logic [2:0]  level;

  always #4 clk = ~clk;   // 125 MHz

  msp_gate_gen u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase_step   (phase_step),
    .carrier_half (carrier_half),
    .mod_index    (mod_index),
    .leg_mode     (leg_mode),
    .gate         (gate),
    .level        (level)
  );

  typedef struct { bit known; int lvl; int mode; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  // independent model state
  bit [31:0] m_phase, m_step;
  int m_per, m_cnt, m_mi, m_mode;
  bit m_up;

  function automatic int n_of(int mode);
    case (mode) 0: return 1; 1: return 2; 2: return 4; default: return 0; endcase
  endfunction

  function automatic logic [7:0] want_gate(int mode, int lvl);
    logic [7:0] g = '0;
    case (mode)
      0: g = (lvl == 1) ? 8'b0000_0001 : 8'b0000_0010;
      1: case (lvl) 2: g = 8'b0000_0011; 1: g = 8'b0000_0110; default: g = 8'b0000_1100; endcase
      2: for (int k = 1; k <= 4; k++) begin
           g[k-1] = (lvl >= 5 - k);
           g[3+k] = !g[k-1];
         end
      default: g = '0;
    endcase
    return g;
  endfunction

  task automatic model_reset();
    m_phase = '0; m_step = '0; m_per = 0; m_cnt = 0; m_mi = 0; m_mode = 3; m_up = 1;
  endtask

  function automatic exp_t predict();
    exp_t e;
    int n;
    real half, u, tol, th;
    n = n_of(m_mode);
    e.mode = m_mode; e.known = 1; e.lvl = 0;
    if (n == 0) return e;
    half = n * m_per / 2.0;
    th   = 2.0 * 3.14159265358979 * (m_phase[31:24] + 0.5) / 256.0;
    u    = half * (1.0 + (m_mi / 256.0) * $sin(th));
    tol  = 0.02 * half + 2.0;
    for (int k = 0; k < n; k++) begin
      real c, d;
      c = k * m_per + m_cnt;
      d = u - c;
      if (d < tol && d > -tol) e.known = 0;
      else if (d > 0) e.lvl++;
    end
    return e;
  endfunction

  task automatic model_step();
    bit pk;
    pk = m_up && (m_cnt >= m_per);
    if (m_up) begin
      if (pk) begin m_up = 0; m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
      else m_cnt = m_cnt + 1;
    end else begin
      if (m_cnt == 0) begin m_up = 1; m_cnt = 1; end
      else m_cnt = m_cnt - 1;
    end
    m_phase = m_phase + m_step;
    if (pk) begin
      m_step = phase_step; m_per = carrier_half; m_mi = mod_index; m_mode = leg_mode;
    end
  endtask

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, expv, cycles);
    end
  endtask

  function automatic string gate_req(int mode);
    case (mode) 0: return "R8"; 1: return "R6"; 2: return "R7"; default: return "R9"; endcase
  endfunction

  // monitor: pops the prediction for the previous cycle, pushes the next one
  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      if (cycles > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
      end
      if (!rst_n) begin
        exp_q.delete();
        model_reset();
        check(gate == 8'h00 && level == 3'd0, "R1", {gate, 5'd0, level}, 0);
      end else begin
        if (exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          check(gate == want_gate(e.mode, level), gate_req(e.mode), gate, want_gate(e.mode, level));
          check($countones(gate) == n_of(e.mode), "R10", $countones(gate), n_of(e.mode));
          check(level <= n_of(e.mode), "R5", level, n_of(e.mode));
          if (e.known)
            check(level == e.lvl, "R2 R3 R4 R5", level, e.lvl);
        end
        exp_q.push_back(predict());
        model_step();
      end
    end
  end

  task automatic setv(int md, int per, int mi, bit [31:0] stp);
    @(posedge clk); #2;
    leg_mode = 2'(md); carrier_half = 16'(per); mod_index = 8'(mi); phase_step = stp;
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  initial begin
    setv(0, 16, 255, 32'h0100_0000);
    do_reset();                               // R1
    run(1200);                                // two-level, R8
    setv(1, 10, 200, 32'h0100_0000); run(1200);   // three-level, R6
    setv(2, 8, 255, 32'h0080_0000);  run(1500);   // five-level, R7
    setv(2, 8, 0, 32'h0080_0000);    run(400);    // centred reference, R4
    setv(3, 8, 255, 32'h0080_0000);  run(200);    // off, R9
    setv(2, 12, 180, 32'h0200_0000); run(300);
    for (int i = 0; i < 100; i++) begin           // changes between peaks, R3
      setv((i % 2 == 0) ? 3 : 0, (i % 3 == 0) ? 6 : 12, 90 + i, 32'h0300_0000);
      run(2);
    end
    setv(1, 14, 255, 32'h0000_0000); run(300);    // frozen phase, R4
    setv(1, 20, 230, 32'h0180_0000); run(200);
    do_reset();                                   // reset mid-run, R1
    run(600);
    setv(2, 6, 128, 32'h0100_0000);  run(800);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule